// File: doc/BRIEF.md
# Port Register Block with Read-Modify-Write Bit Clearer

This block is an 8-bit general-purpose pin port that sits on a simple register bus. It has a direction register, a data latch and a set of hardware event flags. A small bus master sits beside the port and clears one bit of any port register by doing a read, a mask and a write back. A host drives the bus through address, read and write strobes and 8-bit data. Read data comes back combinationally in the cycle of the strobe.

The direction register cannot be read back, and every read of it returns all ones. A bit-clear aimed at it therefore rewrites every other bit as 1, which turns those pins into outputs. The event flags use a read-then-write-zero rule, so a bit-clear aimed at a flag that is already set meets that rule by itself.

Incoming pin levels pass through a synchronizer before register reads can see them. While the bit clearer is running it owns the bus.

Top module: `gpio_bitclr_top`

## Requirements
- R1: `pin_oe` equals the direction register (1 = output, 0 = input) and `pin_out` equals the data latch. Each changes only through a bus write to its own register: direction at address 0, data at address 1.
- R2: A read of address 0 returns 8'hFF whatever the direction register holds. A read of address 3 returns 8'h00, and a write to address 3 changes nothing.
- R3: A bit-clear command reads the target address, clears bit `cmd_bit` of the value read, and writes the result back to the same address. `seq_busy` is low again once the write-back is done.
- R4: If the direction register holds 8'h3F, a bit-clear of address 0 bit 0 leaves it at 8'hFE.
- R5: The event flags sit at address 2. A flag clears only when 0 is written to it after a read of address 2 returned that flag as 1. Writing 0 without such a read, or writing 1, leaves the flag unchanged.
- R6: A bit of `irq_set` high in a cycle sets its flag on the next edge. This holds even when a clearing write to that flag lands on the same edge.
- R7: A command is accepted when `cmd_valid` is high while `seq_busy` is low. `seq_busy` is high for exactly the two following cycles. Commands presented while `seq_busy` is high are ignored.
- R8: A read of address 1 returns the latch bit for each output pin and the synchronized pin level for each input pin.
- R9: A change on `pin_in` shows in address 1 reads only after two clock edges.
- R10: Reset makes all pins inputs, clears the data latch and clears all flags.
- R11: While `seq_busy` is high, host reads and writes are ignored and `host_rdata` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Host register address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid during the read strobe |
| cmd_valid | input | 1 | Bit-clear command request |
| cmd_addr | input | 2 | Register address to modify |
| cmd_bit | input | 3 | Index of the bit to clear |
| seq_busy | output | 1 | Bit clearer owns the bus |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq_set | input | 8 | Hardware flag set pulses |

## Verification
A corrupted direction value shows up on `pin_oe` on the edge after the write that caused it, and there it is seen directly. Wrong flag or arming state stays hidden until the next read of address 2. The bench therefore reads the flags straight after every write and every bit-clear that could change them. A bad synchronizer depth moves the cycle in which a new pin level first appears in an address 1 read, and the bench reads in both the cycle before and the cycle after that point. A sequencer that writes the wrong mask changes `pin_oe` or `pin_out` within three cycles of the command.

// File: rtl/gpio_bitclr_pkg.sv
package gpio_bitclr_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_DAT  = 2'd1,
        SEL_FLG  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bitclr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]          bus_wdata,
    input  logic [W-1:0]          pin_level,
    input  logic [W-1:0]          irq_set,
    output logic [W-1:0]          rd_data,
    output logic [W-1:0]          dir_out,
    output logic [W-1:0]          dat_out
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dat;
        logic [W-1:0] flg;
        logic [W-1:0] arm;
    } regs_t;

    regs_t        st_d, st_q;
    logic [W-1:0] clr_mask;
    reg_sel_e     sel;

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (bus_wr) begin
            case (sel)
                SEL_DIR: st_d.dir = bus_wdata;
                SEL_DAT: st_d.dat = bus_wdata;
                SEL_FLG: begin
                    clr_mask = st_q.arm & ~bus_wdata;
                    st_d.arm = '0;
                end
                default: ;
            endcase
        end
        if (bus_rd && sel == SEL_FLG) begin
            st_d.arm = st_q.arm | st_q.flg;
        end
        st_d.flg = (st_q.flg & ~clr_mask) | irq_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_DIR: rd_data = '1;
            SEL_DAT: rd_data = (st_q.dat & st_q.dir) | (pin_level & ~st_q.dir);
            SEL_FLG: rd_data = st_q.flg;
            default: rd_data = '0;
        endcase
    end

    assign dir_out = st_q.dir;
    assign dat_out = st_q.dat;

endmodule

// File: rtl/gpio_bitclr_seq.sv
module gpio_bitclr_seq
    import gpio_bitclr_pkg::*;
#(
    parameter int W     = 8,
    parameter int BIT_W = $clog2(W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [REG_ADDR_W-1:0] cmd_addr,
    input  logic [BIT_W-1:0]      cmd_bit,
    input  logic [W-1:0]          rd_data,
    output logic                  req_rd,
    output logic                  req_wr,
    output logic [REG_ADDR_W-1:0] req_addr,
    output logic [W-1:0]          req_wdata,
    output logic                  busy
);

    typedef struct packed {
        seq_state_e            state;
        logic [REG_ADDR_W-1:0] addr;
        logic [BIT_W-1:0]      bitsel;
        logic [W-1:0]          data;
    } seq_t;

    seq_t         sq_d, sq_q;
    logic [W-1:0] keep_mask;

    assign keep_mask = ~({{(W-1){1'b0}}, 1'b1} << sq_q.bitsel);

    always_comb begin
        sq_d = sq_q;
        case (sq_q.state)
            SEQ_IDLE: begin
                if (cmd_valid) begin
                    sq_d.state  = SEQ_READ;
                    sq_d.addr   = cmd_addr;
                    sq_d.bitsel = cmd_bit;
                end
            end
            SEQ_READ: begin
                sq_d.data  = rd_data & keep_mask;
                sq_d.state = SEQ_WRITE;
            end
            SEQ_WRITE: sq_d.state = SEQ_IDLE;
            default:   sq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{state: SEQ_IDLE, default: '0};
        else        sq_q <= sq_d;
    end

    assign req_rd    = (sq_q.state == SEQ_READ);
    assign req_wr    = (sq_q.state == SEQ_WRITE);
    assign req_addr  = sq_q.addr;
    assign req_wdata = sq_q.data;
    assign busy      = (sq_q.state != SEQ_IDLE);

endmodule

// File: rtl/gpio_bus_arb.sv
module gpio_bus_arb
    import gpio_bitclr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  seq_own,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic [W-1:0]          host_wdata,
    input  logic                  seq_rd,
    input  logic                  seq_wr,
    input  logic [REG_ADDR_W-1:0] seq_addr,
    input  logic [W-1:0]          seq_wdata,
    input  logic [W-1:0]          slave_rdata,
    output logic                  bus_rd,
    output logic                  bus_wr,
    output logic [REG_ADDR_W-1:0] bus_addr,
    output logic [W-1:0]          bus_wdata,
    output logic [W-1:0]          host_rdata
);

    always_comb begin
        if (seq_own) begin
            bus_rd     = seq_rd;
            bus_wr     = seq_wr;
            bus_addr   = seq_addr;
            bus_wdata  = seq_wdata;
            host_rdata = '0;
        end else begin
            bus_rd     = host_rd;
            bus_wr     = host_wr;
            bus_addr   = host_addr;
            bus_wdata  = host_wdata;
            host_rdata = slave_rdata;
        end
    end

endmodule

// File: rtl/gpio_bitclr_top.sv
module gpio_bitclr_top
    import gpio_bitclr_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int BIT_W      = $clog2(PORT_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [PORT_W-1:0]     host_wdata,
    output logic [PORT_W-1:0]     host_rdata,
    input  logic                  cmd_valid,
    input  logic [REG_ADDR_W-1:0] cmd_addr,
    input  logic [BIT_W-1:0]      cmd_bit,
    output logic                  seq_busy,
    input  logic [PORT_W-1:0]     pin_in,
    output logic [PORT_W-1:0]     pin_out,
    output logic [PORT_W-1:0]     pin_oe,
    input  logic [PORT_W-1:0]     irq_set
);

    logic                  seq_rd, seq_wr;
    logic [REG_ADDR_W-1:0] seq_addr;
    logic [PORT_W-1:0]     seq_wdata;
    logic                  bus_rd, bus_wr;
    logic [REG_ADDR_W-1:0] bus_addr;
    logic [PORT_W-1:0]     bus_wdata;
    logic [PORT_W-1:0]     slave_rdata;
    logic [PORT_W-1:0]     pin_level;

    gpio_pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_level)
    );

    gpio_bitclr_seq #(.W(PORT_W), .BIT_W(BIT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_bit   (cmd_bit),
        .rd_data   (slave_rdata),
        .req_rd    (seq_rd),
        .req_wr    (seq_wr),
        .req_addr  (seq_addr),
        .req_wdata (seq_wdata),
        .busy      (seq_busy)
    );

    gpio_bus_arb #(.W(PORT_W)) arb_i (
        .seq_own     (seq_busy),
        .host_rd     (host_rd),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .seq_rd      (seq_rd),
        .seq_wr      (seq_wr),
        .seq_addr    (seq_addr),
        .seq_wdata   (seq_wdata),
        .slave_rdata (slave_rdata),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .host_rdata  (host_rdata)
    );

    gpio_port_regs #(.W(PORT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_level (pin_level),
        .irq_set   (irq_set),
        .rd_data   (slave_rdata),
        .dir_out   (pin_oe),
        .dat_out   (pin_out)
    );

endmodule

// File: rtl/gpio_bitclr_chk.sv
module gpio_bitclr_chk
    import gpio_bitclr_pkg::*;
#(
    parameter int W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  host_rd,
    input logic [REG_ADDR_W-1:0] host_addr,
    input logic [W-1:0]          host_rdata,
    input logic                  cmd_valid,
    input logic                  seq_busy,
    input logic [W-1:0]          pin_oe,
    input logic [W-1:0]          irq_set,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr
);

    assert_dir_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == SEL_DIR && !seq_busy) |-> host_rdata == '1);

    assert_oe_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == SEL_DIR) |=> $stable(pin_oe));

    assert_wb_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && seq_busy && $past(seq_busy)) |-> bus_addr == $past(bus_addr));

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !seq_busy) |=> seq_busy);

    assert_busy_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |=> seq_busy ##1 !seq_busy);

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == SEL_FLG && !seq_busy && $past(rst_n))
            |-> ((host_rdata & $past(irq_set)) == $past(irq_set)));

    assert_host_mute_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> host_rdata == '0);

endmodule

bind gpio_bitclr_top gpio_bitclr_chk #(.W(PORT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .cmd_valid  (cmd_valid),
    .seq_busy   (seq_busy),
    .pin_oe     (pin_oe),
    .irq_set    (irq_set),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr)
);

// File: tb/gpio_bitclr_top_tb_top.sv
`timescale 1ns/1ps
module gpio_bitclr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_addr = '0;
    logic [2:0] cmd_bit = '0;
    logic       seq_busy;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] irq_set = '0;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    gpio_bitclr_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_bit(cmd_bit),
        .seq_busy(seq_busy), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_set(irq_set)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        step();
        host_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        host_rd = 1'b1; host_addr = a;
        step();
        host_rd = 1'b0;
    endtask

    task automatic bit_clear(input logic [1:0] a, input logic [2:0] b);
        cmd_valid = 1'b1; cmd_addr = a; cmd_bit = b;
        step();
        cmd_valid = 1'b0;
        check("R7 busy after accept", {7'd0, seq_busy}, 8'd1);
        step();
        step();
        check("R3 busy clear after write-back", {7'd0, seq_busy}, 8'd0);
    endtask

    // Scoreboard monitor: compares each read cycle against the queued expectation
    always @(negedge clk) begin
        if (host_rd && rst_n) begin
            if (exp_q.size() == 0) begin
                total++; fails++;
                $display("FAIL monitor: unexpected read, actual %h expected none", host_rdata);
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R10 reset oe", pin_oe, 8'h00);
        check("R10 reset out", pin_out, 8'h00);
        bus_read(2'd2, 8'h00, "R10 reset flags");
        bus_read(2'd1, 8'h00, "R10 reset data read");

        pin_in = 8'hC3;
        step(); step();

        bus_write(2'd0, 8'h3F);
        check("R1 oe follows direction", pin_oe, 8'h3F);
        bus_read(2'd0, 8'hFF, "R2 direction reads ones");
        bus_write(2'd1, 8'hA5);
        check("R1 out follows latch", pin_out, 8'hA5);
        bus_read(2'd1, 8'hE5, "R8 mixed data read");

        pin_in = 8'h03;
        step();
        bus_read(2'd1, 8'hE5, "R9 old level before second edge");
        bus_read(2'd1, 8'h25, "R9 new level after two edges");

        bit_clear(2'd0, 3'd0);
        check("R4 direction after bit-clear", pin_oe, 8'hFE);
        bus_read(2'd1, 8'hA5, "R8 data read after direction change");

        // R7: commands held during busy are ignored
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'hFF);
        cmd_valid = 1'b1; cmd_addr = 2'd1; cmd_bit = 3'd2;
        step();
        cmd_bit = 3'd5;
        step();
        step();
        cmd_valid = 1'b0;
        check("R7 busy ended", {7'd0, seq_busy}, 8'd0);
        check("R7 only first command applied", pin_out, 8'hFB);

        // R11: host traffic during busy is ignored
        cmd_valid = 1'b1; cmd_addr = 2'd1; cmd_bit = 3'd0;
        step();
        cmd_valid = 1'b0;
        host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h00;
        step();
        host_wr = 1'b0;
        bus_read(2'd2, 8'h00, "R11 host read muted while busy");
        check("R11 host write ignored", pin_oe, 8'hFF);
        check("R3 data latch bit-clear", pin_out, 8'hFA);

        // R5 flag clear rule
        irq_set = 8'h81;
        step();
        irq_set = 8'h00;
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, 8'h81, "R5 zero write without read keeps flags");
        bus_write(2'd2, 8'h80);
        bus_read(2'd2, 8'h80, "R5 read then zero clears only bit 0");
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, 8'h80, "R5 writing ones changes nothing");

        // R6: hardware set races the clearing write-back
        cmd_valid = 1'b1; cmd_addr = 2'd2; cmd_bit = 3'd7;
        step();
        cmd_valid = 1'b0;
        step();
        irq_set = 8'h80;
        step();
        irq_set = 8'h00;
        bus_read(2'd2, 8'h80, "R6 set wins over clear");

        bit_clear(2'd2, 3'd7);
        bus_read(2'd2, 8'h00, "R3 flag bit-clear");

        irq_set = 8'h12;
        step();
        irq_set = 8'h00;
        bit_clear(2'd2, 3'd4);
        bus_read(2'd2, 8'h02, "R3 bit-clear leaves other flag");

        bus_read(2'd3, 8'h00, "R2 unused address reads zero");
        bus_write(2'd3, 8'h55);
        check("R2 unused write keeps oe", pin_oe, 8'hFF);
        check("R2 unused write keeps out", pin_out, 8'hFA);

        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check("R10 second reset oe", pin_oe, 8'h00);
        check("R10 second reset out", pin_out, 8'h00);
        bus_read(2'd2, 8'h00, "R10 second reset flags");

        step();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule